// File: doc/BRIEF.md
# Byte Stream to Word Packer

This block connects a byte-wide stream to a port that moves only aligned 32-bit words, with the first byte of each word in the most significant lane. It works in both directions.

In the write direction, incoming bytes fill a four-byte spill register. A full register leaves as one word. Fewer than four bytes stay in the register across any gap in the byte stream, so a caller may deliver a transfer as several chunks of any length. A flush request sends a partly filled register as a word whose unused low lanes are zero.

In the read direction, a request names a byte count. The block fetches whole words only when its holding register is empty and hands out exactly the requested bytes. Any surplus bytes of the last fetched word wait for the next request. A transfer-start pulse empties both registers, which discards anything left over from the previous transfer.

Top module: `bytepack_top`

## Requirements
- R1: After reset, `wo_valid`, `rb_valid` and `wi_ready` are low, while `wr_byte_ready` and `rd_req_ready` are high.
- R2: Every four accepted write bytes leave as one word on `wo_data`, with the earliest byte in bits 31:24 and the latest in bits 7:0.
- R3: When a stretch of write bytes leaves one to three bytes over, no word is emitted, and those bytes remain held.
- R4: Bytes arriving after such a gap first complete the held word, and a word is emitted only once four bytes are held.
- R5: A flush with one to three bytes held emits one word. The held bytes sit in the top lanes in arrival order and the remaining low lanes are zero. The register is then empty.
- R6: A flush with no bytes held emits no word.
- R7: While a word waits on the word port with `wo_ready` low, `wo_data` stays stable and `wr_byte_ready` stays low, so no byte is lost or repeated.
- R8: A read request of N bytes delivers exactly N bytes on `rb_data`, taking each fetched word from bits 31:24 down to bits 7:0. A word is fetched only when no held byte remains, so a request that starts empty with N not a multiple of 4 fetches one word beyond N/4.
- R9: Surplus bytes from a read are served to the next request before any new word is fetched. While a held byte is offered, `wi_ready` is low.
- R10: A one-cycle `xfer_start` pulse empties both registers. A following flush then emits nothing, the next write word holds only later bytes, and the next read starts with a fresh fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Pulse at transfer start; empties both registers |
| wr_byte_valid | input | 1 | Write byte offered |
| wr_byte_ready | output | 1 | Write byte can be taken |
| wr_byte_data | input | 8 | Write byte |
| wr_flush_valid | input | 1 | Flush requested |
| wr_flush_ready | output | 1 | Flush can be taken |
| wo_valid | output | 1 | Packed word offered |
| wo_ready | input | 1 | Word port takes the word |
| wo_data | output | 32 | Packed word, first byte in bits 31:24 |
| rd_req_valid | input | 1 | Read request offered |
| rd_req_ready | output | 1 | No read request outstanding |
| rd_req_len | input | 10 | Requested byte count |
| wi_valid | input | 1 | Fetched word available |
| wi_ready | output | 1 | Block takes a word |
| wi_data | input | 32 | Fetched word, first byte in bits 31:24 |
| rb_valid | output | 1 | Read byte offered |
| rb_ready | input | 1 | Read byte taken |
| rb_data | output | 8 | Read byte |

## Verification
The assertions assume that `xfer_start` arrives only when neither side has a request or a word in flight. The stimulus therefore drains every expected word and byte before it pulses it. They also assume that a byte source or sink keeps its valid signal up until a handshake completes. The driver tasks hold each valid signal high until they see the matching ready at a falling edge. Stalls on `wo_ready` and `rb_ready` come from a fixed cycle pattern. This exercises the hold and back-pressure properties without ever leaving a handshake half done.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Bit position of the least significant bit of byte lane `lane`.
  // Lane 0 is the first byte and sits at the most significant end.
  function automatic int bp_lane_lsb(int nb, int bw, int lane);
    return (nb - 1 - lane) * bw;
  endfunction

  // Words a read must fetch when `held` bytes are buffered and `want` are asked for.
  function automatic int bp_fetch_words(int nb, int held, int want);
    if (want <= held) return 0;
    return (want - held + nb - 1) / nb;
  endfunction

endpackage

// File: rtl/bp_pack.sv
module bp_pack #(
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                xfer_start,
  input  logic                byte_valid,
  output logic                byte_ready,
  input  logic [BW-1:0]       byte_data,
  input  logic                flush_valid,
  output logic                flush_ready,
  output logic                word_valid,
  input  logic                word_ready,
  output logic [NB*BW-1:0]    word_data
);
  import bp_pkg::*;

  localparam int WW = NB * BW;
  localparam int CW = $clog2(NB + 1);
  localparam logic [CW-1:0] FULL = CW'(NB);

  logic [WW-1:0] spill_q;
  logic [CW-1:0] occ_q;

  // Named events for the assertions.
  logic byte_fire, word_fire, flush_fire, pad_event;

  function automatic logic [WW-1:0] lane_put(logic [WW-1:0] w, logic [BW-1:0] b,
                                             logic [CW-1:0] lane);
    logic [WW-1:0] r;
    r = w;
    for (int i = 0; i < NB; i++) begin
      if (lane == CW'(i)) r[bp_lane_lsb(NB, BW, i) +: BW] = b;
    end
    return r;
  endfunction

  assign word_valid  = (occ_q == FULL);
  assign word_data   = spill_q;
  assign byte_ready  = !xfer_start && !flush_valid && (occ_q < FULL);
  assign flush_ready = !xfer_start && (occ_q != FULL);

  assign byte_fire  = byte_valid && byte_ready;
  assign word_fire  = word_valid && word_ready && !xfer_start;
  assign flush_fire = flush_valid && flush_ready;
  assign pad_event  = flush_fire && (occ_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || xfer_start) begin
      occ_q   <= '0;
      spill_q <= '0;
    end else if (word_fire) begin
      occ_q   <= '0;
      spill_q <= '0;
    end else if (pad_event) begin
      occ_q   <= FULL;
    end else if (byte_fire) begin
      spill_q <= lane_put(spill_q, byte_data, occ_q);
      occ_q   <= occ_q + 1'b1;
    end
  end

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready && !xfer_start) |=> (word_valid && $stable(word_data))); // R7
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= FULL); // R3
  AST_PAD_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_event && !xfer_start) |=> word_valid); // R5
  AST_EMPTY_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_fire && occ_q == '0) |=> !word_valid); // R6
  AST_NO_BYTE_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !byte_fire); // R7

endmodule

// File: rtl/bp_unpack.sv
module bp_unpack #(
  parameter int NB    = 4,
  parameter int BW    = 8,
  parameter int LEN_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                xfer_start,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LEN_W-1:0]    req_len,
  input  logic                word_valid,
  output logic                word_ready,
  input  logic [NB*BW-1:0]    word_data,
  output logic                byte_valid,
  input  logic                byte_ready,
  output logic [BW-1:0]       byte_data
);
  localparam int WW = NB * BW;
  localparam int CW = $clog2(NB + 1);

  logic [WW-1:0]    hold_q;
  logic [CW-1:0]    held_q;
  logic [LEN_W-1:0] left_q;

  logic req_fire, fetch_fire, give_fire;

  assign req_ready  = !xfer_start && (left_q == '0);
  assign byte_valid = !xfer_start && (left_q != '0) && (held_q != '0);
  assign word_ready = !xfer_start && (left_q != '0) && (held_q == '0);
  assign byte_data  = hold_q[WW-1 -: BW];

  assign req_fire   = req_valid && req_ready;
  assign fetch_fire = word_valid && word_ready;
  assign give_fire  = byte_valid && byte_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || xfer_start) begin
      hold_q <= '0;
      held_q <= '0;
      left_q <= '0;
    end else begin
      if (req_fire) left_q <= req_len;
      if (fetch_fire) begin
        hold_q <= word_data;
        held_q <= CW'(NB);
      end else if (give_fire) begin
        hold_q <= hold_q << BW;
        held_q <= held_q - 1'b1;
        left_q <= left_q - 1'b1;
      end
    end
  end

  AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_ready && !$past(xfer_start)) |=> (xfer_start || (byte_valid && $stable(byte_data)))); // R8
  AST_HELD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> !word_ready); // R9
  AST_XFER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> (!byte_valid && req_ready)); // R10
  AST_HELD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    held_q <= CW'(NB)); // R8

endmodule

// File: rtl/bytepack_top.sv
module bytepack_top #(
  parameter int NB    = 4,
  parameter int BW    = 8,
  parameter int LEN_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer_start,
  input  logic               wr_byte_valid,
  output logic               wr_byte_ready,
  input  logic [BW-1:0]      wr_byte_data,
  input  logic               wr_flush_valid,
  output logic               wr_flush_ready,
  output logic               wo_valid,
  input  logic               wo_ready,
  output logic [NB*BW-1:0]   wo_data,
  input  logic               rd_req_valid,
  output logic               rd_req_ready,
  input  logic [LEN_W-1:0]   rd_req_len,
  input  logic               wi_valid,
  output logic               wi_ready,
  input  logic [NB*BW-1:0]   wi_data,
  output logic               rb_valid,
  input  logic               rb_ready,
  output logic [BW-1:0]      rb_data
);

  bp_pack #(.NB(NB), .BW(BW)) u_pack (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start),
    .byte_valid(wr_byte_valid), .byte_ready(wr_byte_ready), .byte_data(wr_byte_data),
    .flush_valid(wr_flush_valid), .flush_ready(wr_flush_ready),
    .word_valid(wo_valid), .word_ready(wo_ready), .word_data(wo_data)
  );

  bp_unpack #(.NB(NB), .BW(BW), .LEN_W(LEN_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start),
    .req_valid(rd_req_valid), .req_ready(rd_req_ready), .req_len(rd_req_len),
    .word_valid(wi_valid), .word_ready(wi_ready), .word_data(wi_data),
    .byte_valid(rb_valid), .byte_ready(rb_ready), .byte_data(rb_data)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!wo_valid && !rb_valid && !wi_ready)); // R1

endmodule

// File: tb/sim_bytepack_top.sv
module sim_bytepack_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_start = 1'b0;
  logic wr_byte_valid = 1'b0;
  logic wr_byte_ready;
  logic [7:0] wr_byte_data = '0;
  logic wr_flush_valid = 1'b0;
  logic wr_flush_ready;
  logic wo_valid;
  logic wo_ready = 1'b1;
  logic [31:0] wo_data;
  logic rd_req_valid = 1'b0;
  logic rd_req_ready;
  logic [9:0] rd_req_len = '0;
  logic wi_valid = 1'b0;
  logic wi_ready;
  logic [31:0] wi_data = '0;
  logic rb_valid;
  logic rb_ready = 1'b1;
  logic [7:0] rb_data;

  always #10 clk = ~clk;

  bytepack_top u0 (.*);

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_words[$];
  logic [7:0]  exp_bytes[$];
  int words_seen = 0;
  int fetch_cnt = 0, fetch_exp = 0;
  // write model
  logic [31:0] m_word = '0;
  int m_occ = 0;
  // read model
  int r_pos = 0, r_have = 0;
  int fetch_idx = 0;
  bit take = 0;
  bit stall_w = 0, stall_r = 0;
  int cyc = 0;
  bit done = 0;

  function automatic logic [7:0] src_byte(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  function automatic logic [31:0] src_word(int k);
    return {src_byte(4*k), src_byte(4*k+1), src_byte(4*k+2), src_byte(4*k+3)};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // ready patterns and word source, driven just after the rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    wo_ready = stall_w ? (cyc % 3 == 0) : 1'b1;
    rb_ready = stall_r ? (cyc % 4 != 1) : 1'b1;
    if (take) fetch_idx++;
    wi_data = src_word(fetch_idx);
  end

  // monitor: sampled on the falling edge
  logic [31:0] held_word;
  bit was_stalled = 0;
  always @(negedge clk) begin
    take = 0;
    if (rst_n) begin
      if (was_stalled)
        check(wo_valid && wo_data == held_word, "R7 word held", wo_data, held_word);
      was_stalled = wo_valid && !wo_ready;
      held_word = wo_data;
      if (wo_valid)
        check(!wr_byte_ready, "R7 back-pressure", {31'd0, wr_byte_ready}, 32'd0);
      if (wo_valid && wo_ready) begin
        words_seen++;
        if (exp_words.size() == 0) check(0, "R2 unexpected word", wo_data, 32'hx);
        else begin
          logic [31:0] e;
          e = exp_words.pop_front();
          check(wo_data == e, "R2 word value", wo_data, e);
        end
      end
      if (rb_valid && rb_ready) begin
        if (exp_bytes.size() == 0) check(0, "R8 unexpected byte", {24'd0, rb_data}, 32'hx);
        else begin
          logic [7:0] e;
          e = exp_bytes.pop_front();
          check(rb_data == e, "R8 byte value", {24'd0, rb_data}, {24'd0, e});
        end
      end
      if (wi_valid && wi_ready) begin
        take = 1;
        fetch_cnt++;
      end
    end
  end

  task automatic push_byte(logic [7:0] b);
    @(posedge clk); #2;
    wr_byte_valid = 1; wr_byte_data = b;
    do @(negedge clk); while (!wr_byte_ready);
    @(posedge clk); #2;
    wr_byte_valid = 0;
    m_word[8*(3-m_occ) +: 8] = b;
    m_occ++;
    if (m_occ == 4) begin
      exp_words.push_back(m_word);
      m_word = '0; m_occ = 0;
    end
  endtask

  task automatic flush();
    @(posedge clk); #2;
    wr_flush_valid = 1;
    do @(negedge clk); while (!wr_flush_ready);
    @(posedge clk); #2;
    wr_flush_valid = 0;
    if (m_occ > 0) exp_words.push_back(m_word);
    m_word = '0; m_occ = 0;
  endtask

  task automatic drain();
    while (exp_words.size() != 0 || exp_bytes.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(posedge clk); #2; xfer_start = 1;
    @(posedge clk); #2; xfer_start = 0;
    m_word = '0; m_occ = 0;
    r_pos += r_have; r_have = 0;
  endtask

  task automatic read_req(int n);
    @(posedge clk); #2;
    rd_req_valid = 1; rd_req_len = 10'(n);
    do @(negedge clk); while (!rd_req_ready);
    @(posedge clk); #2;
    rd_req_valid = 0;
    for (int i = 0; i < n; i++) begin
      if (r_have == 0) begin r_have = 4; fetch_exp++; end
      exp_bytes.push_back(src_byte(r_pos));
      r_pos++; r_have--;
    end
    drain();
    check(fetch_cnt == fetch_exp, "R8 fetch count", 32'(fetch_cnt), 32'(fetch_exp));
  endtask

  initial begin
    int w0;
    repeat (3) @(posedge clk);
    #2;
    @(negedge clk);
    // R1 reset state
    check(!wo_valid, "R1 wo_valid", {31'd0, wo_valid}, 0);
    check(!rb_valid, "R1 rb_valid", {31'd0, rb_valid}, 0);
    check(!wi_ready, "R1 wi_ready", {31'd0, wi_ready}, 0);
    check(wr_byte_ready, "R1 wr_byte_ready", {31'd0, wr_byte_ready}, 1);
    check(rd_req_ready, "R1 rd_req_ready", {31'd0, rd_req_ready}, 1);
    @(posedge clk); #2; rst_n = 1; wi_valid = 1;

    // R2 four bytes, first in the top lane
    push_byte(8'hAA); push_byte(8'hBB); push_byte(8'hCC); push_byte(8'hDD);
    drain();
    check(words_seen == 1, "R2 one word", 32'(words_seen), 1);

    // R3 three trailing bytes are held
    push_byte(8'h11); push_byte(8'h22); push_byte(8'h33);
    repeat (4) @(negedge clk);
    check(!wo_valid && words_seen == 1, "R3 no word", 32'(words_seen), 1);

    // R4 next chunk completes the held word first
    push_byte(8'h44); push_byte(8'h55); push_byte(8'h66); push_byte(8'h77); push_byte(8'h88);
    drain();
    check(words_seen == 3, "R4 words after completion", 32'(words_seen), 3);
    push_byte(8'h99);
    push_byte(8'hA1); push_byte(8'hA2);
    repeat (4) @(negedge clk);
    check(words_seen == 3, "R4 accumulate short chunks", 32'(words_seen), 3);

    // R5 flush pads with zeros
    flush();
    drain();
    check(words_seen == 4, "R5 padded word emitted", 32'(words_seen), 4);
    // R6 flush on empty spill is silent
    flush();
    repeat (4) @(negedge clk);
    check(words_seen == 4 && !wo_valid, "R6 empty flush", 32'(words_seen), 4);

    // R7 stalled word port
    stall_w = 1;
    for (int i = 0; i < 13; i++) push_byte(8'(8'h30 + i));
    flush();
    drain();
    stall_w = 0;
    check(words_seen == 8, "R7 all words under stall", 32'(words_seen), 8);

    // R10 write side: held bytes dropped on transfer start
    push_byte(8'hE1); push_byte(8'hE2);
    pulse_start();
    flush();
    repeat (4) @(negedge clk);
    check(words_seen == 8, "R10 flush after start silent", 32'(words_seen), 8);
    push_byte(8'hF1); push_byte(8'hF2); push_byte(8'hF3); push_byte(8'hF4);
    drain();
    check(words_seen == 9, "R10 fresh word", 32'(words_seen), 9);

    // R8 reads, aligned and unaligned
    read_req(8);
    read_req(5);
    // R9 surplus served before fetching
    w0 = fetch_cnt;
    read_req(2);
    read_req(1);
    check(fetch_cnt == w0, "R9 no fetch for held bytes", 32'(fetch_cnt), 32'(w0));
    stall_r = 1;
    read_req(3);
    read_req(7);
    stall_r = 0;
    // R10 read side: surplus discarded on transfer start
    pulse_start();
    w0 = fetch_cnt;
    read_req(4);
    check(fetch_cnt == w0 + 1, "R10 read refetch", 32'(fetch_cnt), 32'(w0 + 1));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule